// File: doc/BRIEF.md
# Fetch Miss Arbiter with Per-Thread Reserved Slots

This block sits between the instruction-fetch front end of a two-thread core and the next cache level. Each thread raises a miss request carrying a line address. Accepted requests are held in a small shared table of outstanding entries, and they are sent downstream strictly in the order they were recorded, whichever thread they came from. The downstream side returns each line tagged with the slot index it was issued under.

Returned lines are written into the owning thread's pair of 64-byte streaming buffers. Decode drains these buffers one line at a time, in order. Admission follows two rules. First, a thread can never take the last slot that the other thread could still use, so both threads can always have a fetch outstanding. Second, a thread must have an empty streaming buffer before a new request from it is taken.

Top module: `fra_fetch_arb`

## Requirements
- R1: Downstream requests are presented in the exact order in which they were recorded, across both threads. A presented request holds its address and slot until `dn_ready` is high.
- R2: A request from a thread is refused when taking a slot would leave the other thread, holding no slot, with no slot it could use. A thread alone may hold up to NSLOTS-1 slots. With 4 slots it may take a third slot only while the other thread holds or can still get one.
- R3: A request from a thread is refused while both of that thread's streaming buffers are occupied.
- R4: When both threads request in the same cycle, one of them is considered and recorded first. That thread is thread 0 after reset, and the choice swaps on every cycle in which both request.
- R5: A response is accepted (`rsp_ready` high) only while the owning thread has a free streaming buffer. The slot is released on the clock edge where the data is written, and it can be allocated again afterwards.
- R6: Returned data goes only to the buffer pair of the thread that owns the slot. Each thread's buffers hand lines to decode in the order they were written. `buf_pop` removes the head line.
- R7: After reset no downstream request is presented, both buffer pairs are empty, and no request is refused for lack of slots.
- R8: A newly recorded request takes the lowest-numbered free slot. When two requests are recorded in one cycle, the first one takes the lower index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Per-thread miss request present |
| req_addr | input | 2 x AW | Per-thread line address |
| req_ready | output | 2 | Request of that thread recorded this cycle |
| dn_valid | output | 1 | Downstream request present |
| dn_addr | output | AW | Downstream line address |
| dn_tid | output | 1 | Thread owning the downstream request |
| dn_slot | output | log2(NSLOTS) | Slot index of the downstream request |
| dn_ready | input | 1 | Next level takes the presented request |
| rsp_valid | input | 1 | Returned line present |
| rsp_slot | input | log2(NSLOTS) | Slot index the line belongs to |
| rsp_data | input | 8 x LINE_BYTES | Returned line |
| rsp_ready | output | 1 | Returned line written this cycle |
| buf_valid | output | 2 | Per-thread head buffer holds a line |
| buf_data | output | 2 x 8 x LINE_BYTES | Per-thread head line |
| buf_pop | input | 2 | Decode consumes the head line of that thread |

## Verification
The bench builds the arbiter with a 16-bit address and a 4-byte line. The slot count, buffer count and reservation stay at 4, 2 and 1. The narrow line keeps returned words readable. With four slots and two buffers per thread, a single thread reaches the reservation limit after three requests, before its buffers fill. The buffer limit is reached separately once two lines wait undrained. The simultaneous-request cases show both the alternating tie-break and the lowest-index slot reuse after responses free the table.

// File: rtl/fra_pkg.sv
package fra_pkg;

    localparam int NTHR = 2;

    // True when a thread holding `own` slots may take one more, given the
    // other thread holds `other`, without eating the other's reservation.
    function automatic logic slot_fits(input int unsigned own,
                                       input int unsigned other,
                                       input int unsigned total,
                                       input int unsigned rsv);
        int unsigned hold;
        hold = (other < rsv) ? (rsv - other) : 0;
        return ((own + other + 1 + hold) <= total);
    endfunction

endpackage

// File: rtl/fra_admit.sv
module fra_admit
    import fra_pkg::*;
#(
    parameter int NSLOTS = 4,
    parameter int RSV    = 1,
    localparam int CW    = $clog2(NSLOTS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          req_v,
    input  logic [1:0][CW-1:0]  own_cnt,
    input  logic [1:0]          buf_full,
    output logic [1:0]          grant,
    output logic                first_o
);

    typedef struct packed {
        logic pri;
    } adm_st_t;

    adm_st_t st_d, st_q;
    logic    g_f, g_s;

    always_comb begin
        st_d  = st_q;
        grant = '0;
        g_f = req_v[st_q.pri] & ~buf_full[st_q.pri]
            & slot_fits(32'(own_cnt[st_q.pri]), 32'(own_cnt[~st_q.pri]),
                        NSLOTS, RSV);
        g_s = req_v[~st_q.pri] & ~buf_full[~st_q.pri]
            & slot_fits(32'(own_cnt[~st_q.pri]),
                        32'(own_cnt[st_q.pri]) + 32'(g_f), NSLOTS, RSV);
        grant[st_q.pri]  = g_f;
        grant[~st_q.pri] = g_s;
        if (&req_v) st_d.pri = ~st_q.pri;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign first_o = st_q.pri;

    // R4: a cycle with both threads requesting swaps the first-considered thread
    assert_tie_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (&req_v) |=> (st_q.pri != $past(st_q.pri)));

    // R3: no thread is granted while its buffers are full
    assert_buf_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & buf_full) == 2'b00);

endmodule

// File: rtl/fra_line_buf.sv
module fra_line_buf #(
    parameter int LINE_W = 512,
    parameter int NBUF   = 2,
    localparam int PW    = (NBUF > 1) ? $clog2(NBUF) : 1,
    localparam int CW    = $clog2(NBUF + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [LINE_W-1:0] wr_data_i,
    input  logic              pop_i,
    output logic              full_o,
    output logic              valid_o,
    output logic [LINE_W-1:0] data_o
);

    typedef struct packed {
        logic [NBUF-1:0][LINE_W-1:0] mem;
        logic [PW-1:0]               rp;
        logic [PW-1:0]               wp;
        logic [CW-1:0]               cnt;
    } lb_st_t;

    lb_st_t st_d, st_q;
    logic   do_wr, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(NBUF - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d   = st_q;
        do_wr  = wr_i && (st_q.cnt < CW'(NBUF));
        do_pop = pop_i && (st_q.cnt != '0);
        if (do_wr) begin
            st_d.mem[st_q.wp] = wr_data_i;
            st_d.wp           = bump(st_q.wp);
        end
        if (do_pop) st_d.rp = bump(st_q.rp);
        st_d.cnt = st_q.cnt + CW'(do_wr) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full_o  = (st_q.cnt == CW'(NBUF));
    assign valid_o = (st_q.cnt != '0);
    assign data_o  = st_q.mem[st_q.rp];

    // R6: the response path never writes a full buffer pair
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> (st_q.cnt < CW'(NBUF)));

endmodule

// File: rtl/fra_fetch_arb.sv
module fra_fetch_arb
    import fra_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 64,
    parameter int NSLOTS     = 4,
    parameter int NBUF       = 2,
    parameter int RSV        = 1,
    localparam int LINE_W    = 8 * LINE_BYTES,
    localparam int SW        = $clog2(NSLOTS),
    localparam int CW        = $clog2(NSLOTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             req_valid,
    input  logic [1:0][AW-1:0]     req_addr,
    output logic [1:0]             req_ready,
    output logic                   dn_valid,
    output logic [AW-1:0]          dn_addr,
    output logic                   dn_tid,
    output logic [SW-1:0]          dn_slot,
    input  logic                   dn_ready,
    input  logic                   rsp_valid,
    input  logic [SW-1:0]          rsp_slot,
    input  logic [LINE_W-1:0]      rsp_data,
    output logic                   rsp_ready,
    output logic [1:0]             buf_valid,
    output logic [1:0][LINE_W-1:0] buf_data,
    input  logic [1:0]             buf_pop
);

    typedef struct packed {
        logic [NSLOTS-1:0]         slot_v;
        logic [NSLOTS-1:0]         slot_tid;
        logic [NSLOTS-1:0][AW-1:0] slot_addr;
        logic [NSLOTS-1:0][SW-1:0] iq;
        logic [CW-1:0]             iq_cnt;
    } arb_st_t;

    arb_st_t           st_d, st_q;
    logic [1:0][CW-1:0] own_cnt;
    logic [1:0]        buf_full;
    logic [1:0]        buf_wr;
    logic [1:0]        grant;
    logic              first;
    logic [SW-1:0]     idx_a, idx_b, sl;
    logic              ok_a, ok_b, use_b, th;
    logic [CW-1:0]     qn;

    // Slots held per thread
    always_comb begin
        own_cnt = '0;
        for (int s = 0; s < NSLOTS; s++) begin
            if (st_q.slot_v[s])
                own_cnt[st_q.slot_tid[s]] = own_cnt[st_q.slot_tid[s]] + CW'(1);
        end
    end

    // Two lowest free slots
    always_comb begin
        idx_a = '0; ok_a = 1'b0;
        idx_b = '0; ok_b = 1'b0;
        for (int s = 0; s < NSLOTS; s++) begin
            if (!st_q.slot_v[s] && !ok_a) begin
                idx_a = SW'(s);
                ok_a  = 1'b1;
            end else if (!st_q.slot_v[s] && !ok_b) begin
                idx_b = SW'(s);
                ok_b  = 1'b1;
            end
        end
    end

    fra_admit #(.NSLOTS(NSLOTS), .RSV(RSV)) admit_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_v    (req_valid),
        .own_cnt  (own_cnt),
        .buf_full (buf_full),
        .grant    (grant),
        .first_o  (first)
    );

    assign req_ready = grant;
    assign dn_valid  = (st_q.iq_cnt != '0);
    assign dn_slot   = st_q.iq[0];
    assign dn_addr   = st_q.slot_addr[dn_slot];
    assign dn_tid    = st_q.slot_tid[dn_slot];
    assign rsp_ready = ~buf_full[st_q.slot_tid[rsp_slot]];

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        assign buf_wr[t] = rsp_valid && rsp_ready && (st_q.slot_tid[rsp_slot] == t);
        fra_line_buf #(.LINE_W(LINE_W), .NBUF(NBUF)) lbuf_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (buf_wr[t]),
            .wr_data_i (rsp_data),
            .pop_i     (buf_pop[t]),
            .full_o    (buf_full[t]),
            .valid_o   (buf_valid[t]),
            .data_o    (buf_data[t])
        );
    end

    always_comb begin
        st_d  = st_q;
        qn    = st_q.iq_cnt;
        use_b = 1'b0;
        sl    = '0;
        th    = 1'b0;
        if (rsp_valid && rsp_ready) st_d.slot_v[rsp_slot] = 1'b0;
        if (dn_valid && dn_ready) begin
            for (int k = 0; k < NSLOTS - 1; k++) st_d.iq[k] = st_q.iq[k+1];
            qn = qn - CW'(1);
        end
        for (int k = 0; k < NTHR; k++) begin
            th = (k == 0) ? first : ~first;
            if (grant[th]) begin
                sl    = use_b ? idx_b : idx_a;
                use_b = 1'b1;
                st_d.slot_v[sl]     = 1'b1;
                st_d.slot_tid[sl]   = th;
                st_d.slot_addr[sl]  = req_addr[th];
                st_d.iq[qn[SW-1:0]] = sl;
                qn = qn + CW'(1);
            end
        end
        st_d.iq_cnt = qn;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: a waiting downstream request stays put
    assert_issue_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_slot)));

    // R2: an idle thread always keeps a slot within reach
    assert_reserve_t0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (own_cnt[1] == '0) |-> (own_cnt[0] <= CW'(NSLOTS - RSV)));
    assert_reserve_t1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (own_cnt[0] == '0) |-> (own_cnt[1] <= CW'(NSLOTS - RSV)));

    // R5: a written response leaves its slot free on the next cycle
    assert_slot_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> !st_q.slot_v[$past(rsp_slot)]);

    // R8: grants never outrun the free slots found
    assert_room_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> ok_a);
    assert_room_two_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (&grant) |-> ok_b);

endmodule

// File: tb/fra_fetch_arb_tb_top.sv
module fra_fetch_arb_tb_top;

    localparam int AW = 16;
    localparam int LB = 4;
    localparam int LW = 8 * LB;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [1:0]         req_valid;
    logic [1:0][AW-1:0] req_addr;
    logic [1:0]         req_ready;
    logic               dn_valid;
    logic [AW-1:0]      dn_addr;
    logic               dn_tid;
    logic [1:0]         dn_slot;
    logic               dn_ready;
    logic               rsp_valid;
    logic [1:0]         rsp_slot;
    logic [LW-1:0]      rsp_data;
    logic               rsp_ready;
    logic [1:0]         buf_valid;
    logic [1:0][LW-1:0] buf_data;
    logic [1:0]         buf_pop;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    fra_fetch_arb #(.AW(AW), .LINE_BYTES(LB), .NSLOTS(4), .NBUF(2), .RSV(1)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .dn_valid(dn_valid), .dn_addr(dn_addr), .dn_tid(dn_tid), .dn_slot(dn_slot),
        .dn_ready(dn_ready),
        .rsp_valid(rsp_valid), .rsp_slot(rsp_slot), .rsp_data(rsp_data),
        .rsp_ready(rsp_ready),
        .buf_valid(buf_valid), .buf_data(buf_data), .buf_pop(buf_pop)
    );

    // {req_valid[1:0], dn_ready, exp req_ready[1:0], exp dn_valid, exp dn_tid, exp dn_slot[1:0]}
    localparam logic [8:0] TBL [11] = '{
        9'b01_0_01_0_0_00,
        9'b01_0_01_1_0_00,
        9'b01_0_01_1_0_00,
        9'b01_0_00_1_0_00,
        9'b10_0_10_1_0_00,
        9'b11_0_00_1_0_00,
        9'b00_1_00_1_0_00,
        9'b00_1_00_1_0_01,
        9'b00_1_00_1_0_10,
        9'b00_1_00_1_1_11,
        9'b00_0_00_0_0_00
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] rv, input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                         input logic dnr, input logic rsv, input logic [1:0] rs,
                         input logic [LW-1:0] rd, input logic [1:0] pp);
        @(negedge clk);
        req_valid = rv; req_addr[0] = a0; req_addr[1] = a1;
        dn_ready = dnr; rsp_valid = rsv; rsp_slot = rs; rsp_data = rd; buf_pop = pp;
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R7 watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        logic [AW-1:0] sb [16];
        int wr_i = 0;
        int rd_i = 0;
        logic pri_m = 1'b0;

        rst_n = 1'b0;
        req_valid = '0; req_addr = '0; dn_ready = 1'b0;
        rsp_valid = 1'b0; rsp_slot = '0; rsp_data = '0; buf_pop = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R7 dn_valid", 64'(dn_valid), 64'd0);
        chk("R7 buf_valid", 64'(buf_valid), 64'd0);

        // Table: admission limits, tie with full table, ordered issue
        for (int i = 0; i < 11; i++) begin
            logic [AW-1:0] a0, a1;
            a0 = 16'h0100 + 16'(i);
            a1 = 16'h0200 + 16'(i);
            drive(TBL[i][8:7], a0, a1, TBL[i][6], 1'b0, 2'd0, '0, 2'b00);
            chk("R2 req_ready", 64'(req_ready), 64'(TBL[i][5:4]));
            chk("R1 dn_valid", 64'(dn_valid), 64'(TBL[i][3]));
            if (TBL[i][3]) begin
                chk("R1 dn_tid", 64'(dn_tid), 64'(TBL[i][2]));
                chk("R8 dn_slot", 64'(dn_slot), 64'(TBL[i][1:0]));
                if (TBL[i][6]) begin
                    chk("R1 dn_addr", 64'(dn_addr), 64'(sb[rd_i]));
                    rd_i++;
                end
            end
            for (int k = 0; k < 2; k++) begin
                logic t;
                t = (k == 0) ? pri_m : ~pri_m;
                if (TBL[i][4 + int'(t)]) begin
                    sb[wr_i] = t ? a1 : a0;
                    wr_i++;
                end
            end
            if (TBL[i][8:7] == 2'b11) pri_m = ~pri_m;
        end
        chk("R1 all issued", 64'(rd_i), 64'(wr_i));

        // Responses into thread 0 buffers (slots 0,1,2 belong to thread 0)
        drive(2'b00, '0, '0, 1'b0, 1'b1, 2'd0, 32'hA0A0_A0A0, 2'b00);
        chk("R5 rsp_ready empty buf", 64'(rsp_ready), 64'd1);
        drive(2'b00, '0, '0, 1'b0, 1'b1, 2'd1, 32'hB1B1_B1B1, 2'b00);
        chk("R6 t0 head valid", 64'(buf_valid), 64'b01);
        chk("R6 t0 head data", 64'(buf_data[0]), 64'h A0A0_A0A0);
        chk("R5 rsp_ready second", 64'(rsp_ready), 64'd1);
        drive(2'b01, 16'h0555, '0, 1'b0, 1'b1, 2'd2, 32'hC2C2_C2C2, 2'b00);
        chk("R5 rsp_ready full buf", 64'(rsp_ready), 64'd0);
        chk("R3 refused when buffers full", 64'(req_ready), 64'd0);
        drive(2'b00, '0, '0, 1'b0, 1'b0, 2'd0, '0, 2'b01);
        chk("R6 head before pop", 64'(buf_data[0]), 64'hA0A0_A0A0);
        chk("R1 nothing new issued", 64'(dn_valid), 64'd0);
        drive(2'b00, '0, '0, 1'b0, 1'b1, 2'd2, 32'hC2C2_C2C2, 2'b00);
        chk("R6 order after pop", 64'(buf_data[0]), 64'hB1B1_B1B1);
        chk("R5 rsp_ready after pop", 64'(rsp_ready), 64'd1);
        drive(2'b00, '0, '0, 1'b0, 1'b0, 2'd0, '0, 2'b01);
        chk("R6 t1 untouched", 64'(buf_valid[1]), 64'd0);
        drive(2'b00, '0, '0, 1'b0, 1'b0, 2'd0, '0, 2'b01);
        chk("R6 third line", 64'(buf_data[0]), 64'hC2C2_C2C2);

        // Tie-break: thread 1 is first now (one simultaneous cycle so far)
        drive(2'b11, 16'h0300, 16'h0400, 1'b0, 1'b0, 2'd0, '0, 2'b00);
        chk("R6 t0 drained", 64'(buf_valid), 64'b00);
        chk("R4 both granted", 64'(req_ready), 64'b11);
        drive(2'b11, 16'h0301, 16'h0401, 1'b0, 1'b0, 2'd0, '0, 2'b00);
        chk("R4 t0 first, t1 reserve-limited", 64'(req_ready), 64'b01);
        drive(2'b00, '0, '0, 1'b1, 1'b0, 2'd0, '0, 2'b00);
        chk("R4 issue t1 first", 64'(dn_tid), 64'd1);
        chk("R4 addr t1", 64'(dn_addr), 64'h0400);
        chk("R5 freed slot reused R8", 64'(dn_slot), 64'd0);
        drive(2'b00, '0, '0, 1'b1, 1'b0, 2'd0, '0, 2'b00);
        chk("R1 then t0", 64'(dn_addr), 64'h0300);
        chk("R8 second slot", 64'(dn_slot), 64'd1);
        drive(2'b00, '0, '0, 1'b1, 1'b0, 2'd0, '0, 2'b00);
        chk("R1 then t0 again", 64'(dn_addr), 64'h0301);
        chk("R8 third slot", 64'(dn_slot), 64'd2);
        drive(2'b00, '0, '0, 1'b1, 1'b0, 2'd0, '0, 2'b00);
        chk("R1 queue empty", 64'(dn_valid), 64'd0);

        // Thread 1 response (slot 3) lands only in thread 1 buffers
        drive(2'b00, '0, '0, 1'b0, 1'b1, 2'd3, 32'hD3D3_D3D3, 2'b00);
        chk("R5 t1 rsp_ready", 64'(rsp_ready), 64'd1);
        drive(2'b00, '0, '0, 1'b0, 1'b0, 2'd0, '0, 2'b00);
        chk("R6 t1 valid only", 64'(buf_valid), 64'b10);
        chk("R6 t1 data", 64'(buf_data[1]), 64'hD3D3_D3D3);

        finish_run();
    end

endmodule